// File: doc/BRIEF.md
# Receiver Power State Controller

This block chooses the power state of a video/audio receiver. It has three kinds of input: a power-down request, given by a control-register bit or by an external pin; six activity flags from the sync detectors; and an auto power-down enable. From these it sets a main power-domain enable and four output-enable controls, one for each output group: video, sync-on-green (SOG) slicer output, S/PDIF and I2S.

Software programs one 8-bit control register through a simple write port. It reads that register, or a status word, through a combinational read port. The external pin has a programmable polarity. A mode bit decides what an asserted pin does: it either forces power-down, or it only disables the output drivers, in which case the SOG output keeps driving.

The domain enable, the four output enables and the state are all registered, so they change only on a clock edge. A synchronous reset returns the block to full power.

Top module: `rx_power_ctrl`

## Requirements
- R1: Reset (synchronous, `rst` high) gives state FULL, `pwr_main`=1, all four output enables 1, and a control register reading 8'h01. A write during reset is ignored.
- R2: State codes are FULL=0, SEEK=1, AUTO_PD=2, PD=3. With `rd_sel`=1, `rd_data` is {act_flags[5:0], state[1:0]}. With `rd_sel`=0, `rd_data` is the control register.
- R3: Control bit 0 is the run bit. When it is 0, the state is PD whatever the activity flags or the auto enable say.
- R4: The pin counts as asserted when `pd_pin` equals control bit 1 (1 means active high, 0 means active low). An asserted pin with control bit 2 = 0 forces state PD, with priority over activity.
- R5: An asserted pin with control bit 2 = 1 does not change the state. It forces the video, S/PDIF and I2S enables to 0 and leaves the SOG enable untouched.
- R6: With no power-down request and any one of the six activity flags set, the state is FULL and `pwr_main`=1.
- R7: With no power-down request, no activity and auto enable (control bit 3) = 0, the state is SEEK and `pwr_main`=1.
- R8: With no power-down request, no activity and auto enable = 1, the state is AUTO_PD and `pwr_main`=0.
- R9: Control bits 4, 5, 6 and 7 each force one enable to 0: video, SOG, S/PDIF and I2S respectively. A set bit affects only its own enable.
- R10: When `pwr_main`=0, the video, S/PDIF and I2S enables are 0. The SOG enable then depends only on control bit 5.
- R11: A change on `pd_pin` or `act_flags` shows on the outputs after one rising edge. A register write shows after two rising edges: one edge stores the value, the next applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Control register write value |
| rd_sel | input | 1 | Read select: 0 = control, 1 = status |
| rd_data | output | 8 | Read data (combinational) |
| pd_pin | input | 1 | External power-down pin |
| act_flags | input | 6 | Sync activity flags |
| pwr_main | output | 1 | Main power-domain enable |
| state | output | 2 | Current power state code |
| oe_video | output | 1 | Video output drive enable |
| oe_sog | output | 1 | SOG output drive enable |
| oe_spdif | output | 1 | S/PDIF output drive enable |
| oe_i2s | output | 1 | I2S output drive enable |

## Verification
The bench keeps a behavioural model that updates on the same rising edge as the design's output registers. Pin and activity stimulus therefore appears in the expected values one edge after it is driven. A register write appears one edge later still, because the model applies a write only after it has computed that cycle's state from the old register value. Inputs change 2 ns after the falling edge, and every output, including the combinational read data, is compared on the falling edge. Directed sequences cover each state, each flag position, both pin polarities and both pin modes, and each high-impedance bit. A long random run follows.

// File: rtl/rx_power_ctrl.sv
module rx_power_ctrl #(
  parameter int          ACT_W    = 6,
  parameter logic [7:0]  CTRL_RST = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             rd_sel,
  output logic [7:0]       rd_data,
  input  logic             pd_pin,
  input  logic [ACT_W-1:0] act_flags,
  output logic             pwr_main,
  output logic [1:0]       state,
  output logic             oe_video,
  output logic             oe_sog,
  output logic             oe_spdif,
  output logic             oe_i2s
);
  localparam logic [1:0] ST_FULL = 2'd0, ST_SEEK = 2'd1, ST_AUTO = 2'd2, ST_PD = 2'd3;

  logic [7:0] ctrl_q;
  logic       pin_act, pd_cmd, tri_pin, sync_act, main_d;
  logic [1:0] state_d;

  assign pin_act  = ~(pd_pin ^ ctrl_q[1]);
  assign pd_cmd   = ~ctrl_q[0] | (pin_act & ~ctrl_q[2]);
  assign tri_pin  = pin_act & ctrl_q[2];
  assign sync_act = |act_flags;
  assign state_d  = pd_cmd ? ST_PD : sync_act ? ST_FULL : ctrl_q[3] ? ST_AUTO : ST_SEEK;
  assign main_d   = (state_d == ST_FULL) || (state_d == ST_SEEK);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      state    <= ST_FULL;
      pwr_main <= 1'b1;
      oe_video <= 1'b1;
      oe_sog   <= 1'b1;
      oe_spdif <= 1'b1;
      oe_i2s   <= 1'b1;
    end else begin
      if (wr_en) ctrl_q <= wr_data;
      state    <= state_d;
      pwr_main <= main_d;
      oe_video <= main_d & ~ctrl_q[4] & ~tri_pin;
      oe_sog   <= ~ctrl_q[5];
      oe_spdif <= main_d & ~ctrl_q[6] & ~tri_pin;
      oe_i2s   <= main_d & ~ctrl_q[7] & ~tri_pin;
    end
  end

  assign rd_data = rd_sel ? {act_flags[5:0], state} : ctrl_q;

  assert_reset_full_R1: assert property (@(posedge clk)
    rst |=> (state == ST_FULL) && pwr_main && oe_video && oe_sog && oe_spdif && oe_i2s);

  assert_pd_priority_R3: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0] |=> (state == ST_PD) && !pwr_main);

  assert_tri_keeps_sog_R5: assert property (@(posedge clk) disable iff (rst)
    (tri_pin && !ctrl_q[5]) |=> oe_sog && !oe_video && !oe_spdif && !oe_i2s);

  assert_activity_full_R6: assert property (@(posedge clk) disable iff (rst)
    (!pd_cmd && sync_act) |=> (state == ST_FULL) && pwr_main);

  assert_seek_powered_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEEK) |-> pwr_main);

  assert_dark_outputs_R10: assert property (@(posedge clk) disable iff (rst)
    !pwr_main |-> !oe_video && !oe_spdif && !oe_i2s);
endmodule

// File: tb/tb_rx_power_ctrl.sv
module tb_rx_power_ctrl;
  logic clk = 0, rst = 1, wr_en = 0, rd_sel = 0, pd_pin = 1;
  logic [7:0] wr_data = 0;
  logic [5:0] act_flags = 0;
  logic [7:0] rd_data;
  logic pwr_main, oe_video, oe_sog, oe_spdif, oe_i2s;
  logic [1:0] state;

  int vectors = 0, errors = 0, cyc = 0;
  int m_ctrl = 1, m_st = 0, m_main = 1;
  int m_oe[4] = '{1, 1, 1, 1};

  rx_power_ctrl dut (.clk, .rst, .wr_en, .wr_data, .rd_sel, .rd_data, .pd_pin, .act_flags,
                     .pwr_main, .state, .oe_video, .oe_sog, .oe_spdif, .oe_i2s);

  always #10 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ctrl = 1; m_st = 0; m_main = 1; m_oe = '{1, 1, 1, 1};
    end else begin
      bit run, pol, tmode, auto_en, pin_on, req, tri_on;
      run = m_ctrl[0]; pol = m_ctrl[1]; tmode = m_ctrl[2]; auto_en = m_ctrl[3];
      pin_on = (pd_pin == pol);
      req = !run || (pin_on && !tmode);
      tri_on = pin_on && tmode;
      if (req) m_st = 3;
      else if (act_flags != 0) m_st = 0;
      else if (auto_en) m_st = 2;
      else m_st = 1;
      m_main = (m_st <= 1);
      m_oe[0] = m_main && !m_ctrl[4] && !tri_on;
      m_oe[1] = !m_ctrl[5];
      m_oe[2] = m_main && !m_ctrl[6] && !tri_on;
      m_oe[3] = m_main && !m_ctrl[7] && !tri_on;
      if (wr_en) m_ctrl = wr_data;
    end
  end

  always @(negedge clk) begin
    string stag;
    case (m_st)
      0: stag = "R6"; 1: stag = "R7"; 2: stag = "R8"; default: stag = "R3";
    endcase
    chk(stag, state, m_st);
    chk("R8 pwr_main", pwr_main, m_main);
    chk("R9 R10 oe_video", oe_video, m_oe[0]);
    chk("R9 oe_sog", oe_sog, m_oe[1]);
    chk("R5 R10 oe_spdif", oe_spdif, m_oe[2]);
    chk("R5 R10 oe_i2s", oe_i2s, m_oe[3]);
    if (rd_sel) chk("R2 status", rd_data, {act_flags, m_st[1:0]});
    else        chk("R1 ctrl", rd_data, m_ctrl[7:0]);
  end

  task automatic step(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic wr(logic [7:0] v);
    wr_en = 1; wr_data = v; step(); wr_en = 0;
  endtask

  initial begin
    #2;
    wr_en = 1; wr_data = 8'h00; step(3); wr_en = 0;   // R1 write in reset ignored
    rst = 0;
    chk("R1 reset state", state, 0);
    step();                                           // R7 seek with no activity
    chk("R7 seek", state, 1);
    for (int i = 0; i < 6; i++) begin                 // R6 each flag
      act_flags = 6'(1 << i); step(); chk("R6 flag", state, 0);
    end
    act_flags = 0;
    wr(8'h09); chk("R11 write not yet applied", state, 1);
    step(); chk("R8 auto pd", state, 2); chk("R8 main off", pwr_main, 0);
    chk("R10 sog stays", oe_sog, 1);
    act_flags = 6'h20; step(); chk("R11 one-edge wake", state, 0);
    wr(8'h08); step(); chk("R3 run bit clear", state, 3);
    wr(8'h01); step();
    pd_pin = 0; step(); chk("R4 low pin", state, 3);
    pd_pin = 1; wr(8'h03); step(); chk("R4 high pin", state, 3);
    pd_pin = 0; step(); chk("R4 released", state, 0);
    wr(8'h07); pd_pin = 1; step(2);
    chk("R5 state kept", state, 0); chk("R5 video off", oe_video, 0);
    chk("R5 sog on", oe_sog, 1);
    pd_pin = 0; wr(8'h11); step(); chk("R9 video hiz", oe_video, 0);
    wr(8'h21); step(); chk("R9 sog hiz", oe_sog, 0);
    wr(8'h41); step(); chk("R9 spdif hiz", oe_spdif, 0);
    wr(8'h81); step(); chk("R9 i2s hiz", oe_i2s, 0);
    rd_sel = 1; step(4);
    for (int k = 0; k < 3000; k++) begin
      act_flags = ($urandom % 3 == 0) ? 6'($urandom) : 6'h0;
      pd_pin = 1'($urandom % 4 == 0);
      rd_sel = 1'($urandom);
      if ($urandom % 5 == 0) begin wr_en = 1; wr_data = 8'($urandom) | 8'h01; end
      else if ($urandom % 40 == 0) begin wr_en = 1; wr_data = 8'($urandom); end
      else wr_en = 0;
      rst = ($urandom % 500 == 0);
      step();
    end
    wr_en = 0; rst = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule